// File: doc/BRIEF.md
# Daisy-Chain Command and Response Frame Codec

This block sits between a host controller and a chain of daisy-connected measurement devices that talk in fixed 32-bit words. On the command side it takes a device address, a register address, a data byte and a broadcast flag. It places them into a 32-bit command word, appends an 8-bit CRC and a fixed trailer, and holds the finished word in an output register behind a ready/valid handshake. The serializer takes one word per accepted request.

On the response side it takes a received 32-bit word and checks the CRC carried inside it. It decodes the word in both of the layouts a device can return. A conversion result gives a channel number and a 12-bit sample. A register readback gives a register address, a data byte and a write-acknowledge flag. The caller knows which kind of read it started and picks the matching fields. The block also drives a constant filler word, which is the command sent while a read is being clocked out.

The checksum is a CRC-8 with generator 0x2F. It is run MSB first from zero over every byte of the covered bits except the last one. The last byte is then XORed in without any further polynomial step. The fixed trailer bits at the bottom of a word are never part of the check.

Top module: `daisy_frame_codec`

## Requirements
- R1: A command word holds the device address in bits 31:27, the register address in bits 26:21, the data byte in bits 20:13, the broadcast flag in bit 12, and a zero in bit 11.
- R2: Command bits 10:3 hold a CRC over bits 31:11, read as a 24-bit value with three leading zeros. The two upper bytes of that value are run MSB first through generator 0x2F from a zero start, and the result is XORed with the low byte.
- R3: Command bits 2:0 always hold 3'b010.
- R4: `cmd_ready` is high when no word is pending or the pending word is taken in the same cycle. An accepted request shows `frm_valid` high in the next cycle. Each accepted request yields exactly one word, in order.
- R5: While `frm_valid` is high and `frm_ready` is low, `frm_word` and `frm_valid` stay unchanged.
- R6: `rsp_crc_ok` is high exactly when response bits 9:2 equal the CRC of bits 31:10, computed as in R2 with two leading zeros. Response bits 1:0 have no effect on it.
- R7: Conversion decode gives the device address from bits 31:27, a 4-bit channel from bits 26:23 and 12-bit data from bits 22:11.
- R8: Readback decode gives a 6-bit register address from bits 26:21, 8-bit data from bits 20:13, and the write-acknowledge flag from bit 10.
- R9: Decoded response outputs and the one-cycle pulse `rsp_out_valid` appear one cycle after the `rsp_valid` cycle that supplied the word.
- R10: `read_filler` equals 0xF800030A. This is the command word for device address 0x1F with all other fields zero.
- R11: During and right after reset, `frm_valid` and `rsp_out_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request present |
| cmd_ready | output | 1 | Command request accepted this cycle when high with cmd_valid |
| cmd_dev | input | 5 | Target device address |
| cmd_reg | input | 6 | Target register address |
| cmd_val | input | 8 | Data byte to write |
| cmd_bcast | input | 1 | Broadcast to all devices |
| frm_valid | output | 1 | Command word pending |
| frm_ready | input | 1 | Serializer takes the pending word |
| frm_word | output | 32 | Finished command word |
| rsp_valid | input | 1 | Received word present |
| rsp_word | input | 32 | Received 32-bit word |
| rsp_out_valid | output | 1 | Decoded response present |
| rsp_crc_ok | output | 1 | Response CRC matches |
| rsp_dev | output | 5 | Responding device address |
| rsp_chan | output | 4 | Conversion channel number |
| rsp_conv | output | 12 | Conversion sample |
| rsp_reg | output | 6 | Readback register address |
| rsp_data | output | 8 | Readback data byte |
| rsp_ack | output | 1 | Write-acknowledge flag |
| read_filler | output | 32 | Constant word sent while clocking out a read |

## Verification
The hardest case to reach from the ports is a new request being accepted in the same cycle that the pending word is taken. A second hard case is a request that waits behind a stalled word that must not change. To reach both, the stimulus holds `cmd_valid` high across bursts of requests. It drives `frm_ready` in three modes: always high, pseudo-random, and held low. A scoreboard queue matches every word that leaves against the word computed when its request was accepted. The CRC reference is anchored to the filler constant. Corrupted response words, with single bits flipped inside and outside the covered range, exercise both outcomes of the check.

// File: rtl/daisy_frame_pkg.sv
package daisy_frame_pkg;

   localparam int FRAME_W = 32;
   localparam int CRC_W   = 8;
   localparam int FOLD_W  = 24;

   // Run the upper bytes through the generator MSB first, then fold the
   // low byte in by XOR only.
   function automatic logic [CRC_W-1:0] crc_fold(input logic [FOLD_W-1:0] v,
                                                 input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = '0;
      for (int i = FOLD_W - 1; i >= CRC_W; i--) begin
         fb = c[CRC_W-1] ^ v[i];
         c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return c ^ v[CRC_W-1:0];
   endfunction

   // Complete a command word whose upper 21 bits are already placed.
   function automatic logic [FRAME_W-1:0] seal_cmd(input logic [FRAME_W-1:0] f,
                                                   input logic [CRC_W-1:0] poly);
      return {f[31:11], crc_fold({3'b000, f[31:11]}, poly), 3'b010};
   endfunction

endpackage

// File: rtl/daisy_crc8.sv
module daisy_crc8 #(
   parameter int          MSG_W = 21,
   parameter logic [7:0]  POLY  = 8'h2F
) (
   input  logic [MSG_W-1:0] msg,
   output logic [7:0]       crc
);
   import daisy_frame_pkg::*;

   localparam int PAD_W = FOLD_W - MSG_W;

   if (MSG_W > FOLD_W || MSG_W <= CRC_W) begin : g_bad_width
      $error("daisy_crc8: MSG_W must lie in (8, 24]");
   end

   logic [FOLD_W-1:0] ext;

   if (PAD_W > 0) begin : g_pad
      assign ext = {{PAD_W{1'b0}}, msg};
   end else begin : g_nopad
      assign ext = msg;
   end

   assign crc = crc_fold(ext, POLY);

endmodule

// File: rtl/daisy_cmd_build.sv
module daisy_cmd_build #(
   parameter int         DEV_W = 5,
   parameter int         REG_W = 6,
   parameter int         VAL_W = 8,
   parameter logic [7:0] POLY  = 8'h2F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [DEV_W-1:0] cmd_dev,
   input  logic [REG_W-1:0] cmd_reg,
   input  logic [VAL_W-1:0] cmd_val,
   input  logic             cmd_bcast,
   output logic             frm_valid,
   input  logic             frm_ready,
   output logic [31:0]      frm_word
);
   localparam int DEV_LSB = 32 - DEV_W;
   localparam int REG_LSB = DEV_LSB - REG_W;
   localparam int VAL_LSB = REG_LSB - VAL_W;
   localparam int BC_BIT  = VAL_LSB - 1;
   localparam int MSG_W   = 21;

   if (BC_BIT != 12) begin : g_bad_layout
      $error("daisy_cmd_build: fields must end at bit 13");
   end

   logic [31:0]      raw;
   logic [7:0]       crc;
   logic [31:0]      sealed;
   logic             accept;

   always_comb begin
      raw                       = '0;
      raw[31:DEV_LSB]           = cmd_dev;
      raw[DEV_LSB-1:REG_LSB]    = cmd_reg;
      raw[REG_LSB-1:VAL_LSB]    = cmd_val;
      raw[BC_BIT]               = cmd_bcast;
   end

   daisy_crc8 #(.MSG_W(MSG_W), .POLY(POLY)) u_crc (
      .msg (raw[31:11]),
      .crc (crc)
   );

   assign sealed    = {raw[31:11], crc, 3'b010};
   assign cmd_ready = !frm_valid || frm_ready;
   assign accept    = cmd_valid && cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frm_valid <= 1'b0;
         frm_word  <= '0;
      end else if (accept) begin
         frm_valid <= 1'b1;
         frm_word  <= sealed;
      end else if (frm_ready) begin
         frm_valid <= 1'b0;
      end
   end

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_ready |=> frm_valid && $stable(frm_word));

   assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> frm_valid);

   assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && frm_ready && !cmd_valid |=> !frm_valid);

endmodule

// File: rtl/daisy_rsp_check.sv
module daisy_rsp_check #(
   parameter int         DEV_W   = 5,
   parameter int         CH_W    = 4,
   parameter int         CONV_W  = 12,
   parameter int         REG_W   = 6,
   parameter int         VAL_W   = 8,
   parameter logic [7:0] POLY    = 8'h2F,
   parameter bit         RSP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_valid,
   input  logic [31:0]       rsp_word,
   output logic              rsp_out_valid,
   output logic              rsp_crc_ok,
   output logic [DEV_W-1:0]  rsp_dev,
   output logic [CH_W-1:0]   rsp_chan,
   output logic [CONV_W-1:0] rsp_conv,
   output logic [REG_W-1:0]  rsp_reg,
   output logic [VAL_W-1:0]  rsp_data,
   output logic              rsp_ack
);
   localparam int DEV_LSB  = 32 - DEV_W;
   localparam int CH_LSB   = DEV_LSB - CH_W;
   localparam int CONV_LSB = CH_LSB - CONV_W;
   localparam int REG_LSB  = DEV_LSB - REG_W;
   localparam int VAL_LSB  = REG_LSB - VAL_W;
   localparam int ACK_BIT  = 10;
   localparam int MSG_W    = 32 - ACK_BIT;

   if (CONV_LSB != 11 || VAL_LSB != 13) begin : g_bad_layout
      $error("daisy_rsp_check: response fields do not fit the word");
   end

   logic [31:0] held_word;
   logic        held_v;
   logic [7:0]  calc_crc;

   if (RSP_REG) begin : g_staged
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held_v    <= 1'b0;
            held_word <= '0;
         end else begin
            held_v <= rsp_valid;
            if (rsp_valid) held_word <= rsp_word;
         end
      end

      assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |=> rsp_out_valid);

      assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !rsp_valid |=> !rsp_out_valid);

      assert_dev_R7: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |=> rsp_dev == $past(rsp_word[31:DEV_LSB]));

      assert_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |=> rsp_ack == $past(rsp_word[ACK_BIT]));
   end else begin : g_direct
      assign held_v    = rsp_valid;
      assign held_word = rsp_word;
   end

   daisy_crc8 #(.MSG_W(MSG_W), .POLY(POLY)) u_crc (
      .msg (held_word[31:ACK_BIT]),
      .crc (calc_crc)
   );

   assign rsp_out_valid = held_v;
   assign rsp_crc_ok    = (calc_crc == held_word[9:2]);
   assign rsp_dev       = held_word[31:DEV_LSB];
   assign rsp_chan      = held_word[DEV_LSB-1:CH_LSB];
   assign rsp_conv      = held_word[CH_LSB-1:CONV_LSB];
   assign rsp_reg       = held_word[DEV_LSB-1:REG_LSB];
   assign rsp_data      = held_word[REG_LSB-1:VAL_LSB];
   assign rsp_ack       = held_word[ACK_BIT];

endmodule

// File: rtl/daisy_frame_codec.sv
module daisy_frame_codec #(
   parameter int         DEV_W   = 5,
   parameter int         REG_W   = 6,
   parameter int         VAL_W   = 8,
   parameter int         CH_W    = 4,
   parameter int         CONV_W  = 12,
   parameter logic [7:0] POLY    = 8'h2F,
   parameter bit         RSP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [DEV_W-1:0]  cmd_dev,
   input  logic [REG_W-1:0]  cmd_reg,
   input  logic [VAL_W-1:0]  cmd_val,
   input  logic              cmd_bcast,
   output logic              frm_valid,
   input  logic              frm_ready,
   output logic [31:0]       frm_word,
   input  logic              rsp_valid,
   input  logic [31:0]       rsp_word,
   output logic              rsp_out_valid,
   output logic              rsp_crc_ok,
   output logic [DEV_W-1:0]  rsp_dev,
   output logic [CH_W-1:0]   rsp_chan,
   output logic [CONV_W-1:0] rsp_conv,
   output logic [REG_W-1:0]  rsp_reg,
   output logic [VAL_W-1:0]  rsp_data,
   output logic              rsp_ack,
   output logic [31:0]       read_filler
);
   import daisy_frame_pkg::*;

   localparam logic [31:0] FILL_RAW  = {{DEV_W{1'b1}}, {(32-DEV_W){1'b0}}};
   localparam logic [31:0] FILL_WORD = seal_cmd(FILL_RAW, POLY);

   if (DEV_W + REG_W + VAL_W != 19) begin : g_bad_cmd
      $error("daisy_frame_codec: command fields must total 19 bits");
   end
   if (DEV_W + CH_W + CONV_W != 21) begin : g_bad_conv
      $error("daisy_frame_codec: conversion fields must total 21 bits");
   end

   daisy_cmd_build #(
      .DEV_W (DEV_W), .REG_W (REG_W), .VAL_W (VAL_W), .POLY (POLY)
   ) u_build (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_dev   (cmd_dev),
      .cmd_reg   (cmd_reg),
      .cmd_val   (cmd_val),
      .cmd_bcast (cmd_bcast),
      .frm_valid (frm_valid),
      .frm_ready (frm_ready),
      .frm_word  (frm_word)
   );

   daisy_rsp_check #(
      .DEV_W (DEV_W), .CH_W (CH_W), .CONV_W (CONV_W), .REG_W (REG_W),
      .VAL_W (VAL_W), .POLY (POLY), .RSP_REG (RSP_REG)
   ) u_check (
      .clk           (clk),
      .rst_n         (rst_n),
      .rsp_valid     (rsp_valid),
      .rsp_word      (rsp_word),
      .rsp_out_valid (rsp_out_valid),
      .rsp_crc_ok    (rsp_crc_ok),
      .rsp_dev       (rsp_dev),
      .rsp_chan      (rsp_chan),
      .rsp_conv      (rsp_conv),
      .rsp_reg       (rsp_reg),
      .rsp_data      (rsp_data),
      .rsp_ack       (rsp_ack)
   );

   assign read_filler = FILL_WORD;

   assert_filler_R10: assert property (@(posedge clk) disable iff (!rst_n)
      read_filler[2:0] == 3'b010 && read_filler[31:32-DEV_W] == {DEV_W{1'b1}});

endmodule

// File: tb/daisy_frame_codec_test.sv
module daisy_frame_codec_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [4:0]  cmd_dev = '0;
   logic [5:0]  cmd_reg = '0;
   logic [7:0]  cmd_val = '0;
   logic        cmd_bcast = 1'b0;
   logic        frm_valid;
   logic        frm_ready = 1'b1;
   logic [31:0] frm_word;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_word = '0;
   logic        rsp_out_valid, rsp_crc_ok, rsp_ack;
   logic [4:0]  rsp_dev;
   logic [3:0]  rsp_chan;
   logic [11:0] rsp_conv;
   logic [5:0]  rsp_reg;
   logic [7:0]  rsp_data;
   logic [31:0] read_filler;

   int total = 0;
   int bad = 0;
   int bp_mode = 0;
   bit finished = 1'b0;
   int sent = 0;
   int taken = 0;
   logic [31:0] exp_q[$];

   always #2 clk = ~clk;

   daisy_frame_codec uut (
      .clk (clk), .rst_n (rst_n),
      .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
      .cmd_dev (cmd_dev), .cmd_reg (cmd_reg), .cmd_val (cmd_val),
      .cmd_bcast (cmd_bcast),
      .frm_valid (frm_valid), .frm_ready (frm_ready), .frm_word (frm_word),
      .rsp_valid (rsp_valid), .rsp_word (rsp_word),
      .rsp_out_valid (rsp_out_valid), .rsp_crc_ok (rsp_crc_ok),
      .rsp_dev (rsp_dev), .rsp_chan (rsp_chan), .rsp_conv (rsp_conv),
      .rsp_reg (rsp_reg), .rsp_data (rsp_data), .rsp_ack (rsp_ack),
      .read_filler (read_filler)
   );

   function automatic logic [7:0] ref_crc(input logic [23:0] v);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int i = 23; i >= 8; i--) begin
         fb = c[7] ^ v[i];
         c  = {c[6:0], 1'b0} ^ (fb ? 8'h2F : 8'h00);
      end
      return c ^ v[7:0];
   endfunction

   function automatic logic [31:0] ref_cmd(input logic [4:0] d, input logic [5:0] r,
                                           input logic [7:0] v, input logic b);
      logic [20:0] m;
      m = {d, r, v, b, 1'b0};
      return {m, ref_crc({3'b000, m}), 3'b010};
   endfunction

   function automatic logic [31:0] ref_rsp(input logic [21:0] m, input logic [1:0] tail);
      return {m, ref_crc({2'b00, m}), tail};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // frm_ready pattern: 0 always high, 1 pseudo-random, 2 held low
   always @(posedge clk) begin
      #1;
      case (bp_mode)
         0: frm_ready = 1'b1;
         1: frm_ready = ($urandom % 3) != 0;
         default: frm_ready = 1'b0;
      endcase
   end

   // Monitor: scoreboard for command words and hold check
   logic        prev_stall = 1'b0;
   logic [31:0] prev_word = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            chk(frm_valid == 1'b1, "R5 valid held", {31'b0, frm_valid}, 32'h1);
            chk(frm_word == prev_word, "R5 word held", frm_word, prev_word);
         end
         if (frm_valid && frm_ready) begin
            taken++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4 extra word", frm_word, 32'h0);
            end else begin
               logic [31:0] e;
               e = exp_q.pop_front();
               chk(frm_word == e, "R1 R2 R3 word", frm_word, e);
               chk(frm_word[2:0] == 3'b010, "R3 trailer", {29'b0, frm_word[2:0]}, 32'h2);
            end
         end
         prev_stall = frm_valid && !frm_ready;
         prev_word  = frm_word;
      end
   end

   // Called at posedge+1; returns at posedge+1 after the accepting edge.
   task automatic send_cmd(input logic [4:0] d, input logic [5:0] r,
                           input logic [7:0] v, input logic b);
      bit acc;
      cmd_dev = d; cmd_reg = r; cmd_val = v; cmd_bcast = b; cmd_valid = 1'b1;
      acc = 1'b0;
      while (!acc) begin
         @(negedge clk);
         acc = cmd_ready;
         if (acc) begin
            exp_q.push_back(ref_cmd(d, r, v, b));
            sent++;
         end
         @(posedge clk); #1;
      end
   endtask

   task automatic idle();
      cmd_valid = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic send_rsp(input logic [31:0] w, input bit exp_ok, input bit conv,
                           input string req);
      rsp_word = w; rsp_valid = 1'b1;
      @(posedge clk); #1;
      rsp_valid = 1'b0;
      @(negedge clk);
      chk(rsp_out_valid == 1'b1, "R9 pulse", {31'b0, rsp_out_valid}, 32'h1);
      chk(rsp_crc_ok == exp_ok, {"R6 ", req}, {31'b0, rsp_crc_ok}, {31'b0, exp_ok});
      chk(rsp_dev == w[31:27], "R7 dev", {27'b0, rsp_dev}, {27'b0, w[31:27]});
      if (conv) begin
         chk(rsp_chan == w[26:23], "R7 chan", {28'b0, rsp_chan}, {28'b0, w[26:23]});
         chk(rsp_conv == w[22:11], "R7 conv", {20'b0, rsp_conv}, {20'b0, w[22:11]});
      end else begin
         chk(rsp_reg == w[26:21], "R8 reg", {26'b0, rsp_reg}, {26'b0, w[26:21]});
         chk(rsp_data == w[20:13], "R8 data", {24'b0, rsp_data}, {24'b0, w[20:13]});
         chk(rsp_ack == w[10], "R8 ack", {31'b0, rsp_ack}, {31'b0, w[10]});
      end
      @(negedge clk);
      chk(rsp_out_valid == 1'b0, "R9 single pulse", {31'b0, rsp_out_valid}, 32'h0);
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(frm_valid == 1'b0, "R11 frm_valid in reset", {31'b0, frm_valid}, 32'h0);
      chk(rsp_out_valid == 1'b0, "R11 rsp_out_valid in reset", {31'b0, rsp_out_valid}, 32'h0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R11 cmd_ready after reset", {31'b0, cmd_ready}, 32'h1);
      chk(frm_valid == 1'b0, "R11 frm_valid after reset", {31'b0, frm_valid}, 32'h0);
      chk(read_filler == 32'hF800030A, "R10 filler", read_filler, 32'hF800030A);
      chk(ref_cmd(5'h1F, 6'h00, 8'h00, 1'b0) == 32'hF800030A, "R2 reference anchor",
          ref_cmd(5'h1F, 6'h00, 8'h00, 1'b0), 32'hF800030A);
      @(posedge clk); #1;

      // R1 R2 R3: hand-picked corners, ready always high
      send_cmd(5'h00, 6'h00, 8'h00, 1'b0);
      idle();
      send_cmd(5'h1F, 6'h3F, 8'hFF, 1'b1);
      idle();
      send_cmd(5'h00, 6'h0D, 8'hA0, 1'b1);
      send_cmd(5'h10, 6'h1C, 8'h34, 1'b0);
      send_cmd(5'h01, 6'h20, 8'h01, 1'b0);
      idle();
      @(negedge clk);
      chk(exp_q.size() == 0, "R4 burst drained", exp_q.size(), 32'h0);
      @(posedge clk); #1;

      // R4 R5: stalled word with a waiting request
      bp_mode = 2;
      @(posedge clk); #1;
      send_cmd(5'h0A, 6'h15, 8'h5A, 1'b0);
      cmd_dev = 5'h15; cmd_reg = 6'h2A; cmd_val = 8'hA5; cmd_bcast = 1'b1;
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(cmd_ready == 1'b0, "R4 blocked while stalled", {31'b0, cmd_ready}, 32'h0);
         chk(frm_valid == 1'b1, "R4 word pending", {31'b0, frm_valid}, 32'h1);
      end
      @(posedge clk); #1;
      bp_mode = 0;
      send_cmd(5'h15, 6'h2A, 8'hA5, 1'b1);
      idle();
      idle();

      // R4: random back-pressure with continuous requests
      bp_mode = 1;
      for (int n = 0; n < 60; n++) begin
         send_cmd(5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom));
         if (n % 7 == 3) idle();
      end
      idle();
      bp_mode = 0;
      repeat (4) @(posedge clk);
      #1;
      @(negedge clk);
      chk(exp_q.size() == 0, "R4 all words left", exp_q.size(), 32'h0);
      chk(taken == sent, "R4 one word per request", taken, sent);
      @(posedge clk); #1;

      // R6 R7 R8 R9: responses
      send_rsp(ref_rsp({5'h03, 4'h2, 12'hABC, 1'b0}, 2'b00), 1'b1, 1'b1, "good conversion");
      send_rsp(ref_rsp({5'h1F, 4'hB, 12'hFFF, 1'b1}, 2'b00), 1'b1, 1'b1, "good conversion max");
      send_rsp(ref_rsp({5'h04, 6'h0E, 8'h9C, 2'b00, 1'b1}, 2'b00), 1'b1, 1'b0, "good readback ack");
      send_rsp(ref_rsp({5'h00, 6'h13, 8'h00, 2'b00, 1'b0}, 2'b00), 1'b1, 1'b0, "good readback");
      send_rsp(ref_rsp({5'h07, 4'h5, 12'h123, 1'b0}, 2'b11), 1'b1, 1'b1, "tail ignored");
      send_rsp(ref_rsp({5'h07, 4'h5, 12'h123, 1'b0}, 2'b00) ^ 32'h0010_0000, 1'b0, 1'b1,
               "flip in data");
      send_rsp(ref_rsp({5'h07, 4'h5, 12'h123, 1'b0}, 2'b00) ^ 32'h0000_0020, 1'b0, 1'b1,
               "flip in crc");
      send_rsp(ref_rsp({5'h12, 6'h2D, 8'h7E, 2'b00, 1'b1}, 2'b00) ^ 32'h0000_0400, 1'b0, 1'b0,
               "flip ack");
      send_rsp(ref_rsp({5'h12, 6'h2D, 8'h7E, 2'b00, 1'b1}, 2'b00) ^ 32'h8000_0000, 1'b0, 1'b0,
               "flip top");
      for (int n = 0; n < 20; n++) begin
         logic [21:0] m;
         m = 22'($urandom);
         send_rsp(ref_rsp(m, 2'($urandom)), 1'b1, n[0], "random good");
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule